// File: doc/BRIEF.md
# Custom Opcode Redirect Table

This block sits next to an instruction decoder and lets a small group of shared custom R-type encodings change meaning at run time. It keeps a table of slots, one per shared opcode, and each slot holds a wide extension identifier. Software binds an extension to a slot with an open operation and unbinds it with a close operation. A close writes an all-ones marker that never matches any extension.

When the decoder presents shared opcode N, the block reads slot N and compares the stored identifier with each built-in extension identifier, starting at index 0. The first match drives a one-hot select for that extension. The operands are forwarded with function index N, so the chosen unit runs its own function N. If nothing matches, the instruction is flagged illegal.

A table write takes one cycle and raises a stall for that cycle. A dispatch that names the slot being rewritten is not accepted in that cycle. The decoder presents it again and it then sees the new binding.

Top module: `opc_redirect`

## Requirements
- R1: After reset every slot holds the all-ones marker, `outValid` and `illegal` are low, and a dispatch to any slot is reported illegal.
- R2: An open (`cfgOp`=0) writes `cfgId` into slot `cfgSlot`. A later dispatch to that slot whose identifier equals extension k drives `outValid` high with bit k of `outExtSel` set. A new open on the same slot replaces the old binding.
- R3: A close (`cfgOp`=1) writes the all-ones marker into the slot, and later dispatches to it are reported illegal.
- R4: Identifiers are compared from extension index 0 upward and the lowest matching index wins. `outExtSel` has exactly one bit set whenever `outValid` is high.
- R5: A dispatch whose slot identifier matches no extension raises `illegal` with `outValid` low and `outExtSel` zero.
- R6: An accepted dispatch produces its result on the cycle after the decode cycle, with `outFunc` equal to N and `outRs1`, `outRs2`, `outRd` equal to the decoded fields. Cycles with no accepted dispatch and no rejected table operation leave both `outValid` and `illegal` low.
- R7: `stall` is high during exactly the cycles in which `cfgValid` is high.
- R8: A dispatch presented in the same cycle as a write to its own slot is not accepted and produces no result on the next cycle. When it is presented again on the following cycle, it uses the newly written value.
- R9: A dispatch presented in the same cycle as a write to a different slot is accepted normally.
- R10: An open or close with `cfgSlot` of NUM_SLOTS or more leaves the table unchanged and raises `illegal` (with `outValid` low) on the next cycle. No dispatch is accepted in that cycle.
- R11: `outValid` and `illegal` are never high together.
- R12: Opening a slot with the all-ones identifier leaves it unbound, so dispatches to it are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgValid | input | 1 | Table operation request this cycle |
| cfgOp | input | 1 | 0 = open (bind), 1 = close (unbind) |
| cfgSlot | input | SLOT_W+1 | Slot number, with one extra bit so out-of-range numbers can be expressed |
| cfgId | input | ID_W | Extension identifier used by an open |
| decValid | input | 1 | Shared opcode decoded this cycle |
| decFunc | input | SLOT_W | Which shared opcode (slot number N) |
| decRs1 | input | REG_W | First source register field |
| decRs2 | input | REG_W | Second source register field |
| decRd | input | REG_W | Destination register field |
| stall | output | 1 | Table write in progress this cycle |
| outValid | output | 1 | Routed dispatch strobe |
| outExtSel | output | NUM_EXT | One-hot extension select |
| outFunc | output | SLOT_W | Function index forwarded to the extension |
| outRs1 | output | REG_W | Forwarded first source field |
| outRs2 | output | REG_W | Forwarded second source field |
| outRd | output | REG_W | Forwarded destination field |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The bench builds the block with three extensions, and extensions 0 and 2 share the same identifier. With this build, the first-match priority can be observed at the ports: an identifier bound to both must always select index 0. An identifier bound to neither, and the all-ones value, test the miss path. Eight slots with a 4-bit slot number make the out-of-range values 8 to 15 reachable. This allows rejected opens to be checked against a later dispatch to the in-range slot that shares the same low bits.

// File: rtl/redir_pkg.sv
package redir_pkg;

  typedef enum logic {
    CFG_OPEN  = 1'b0,
    CFG_CLOSE = 1'b1
  } cfgOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tblWrite;   // commit a slot update this cycle
    logic tblClear;   // update writes the unbound marker
    logic issue;      // dispatch accepted this cycle
    logic cfgFault;   // table request with an out-of-range slot
  } redirStrobe_t;

endpackage

// File: rtl/redir_ctrl.sv
module redir_ctrl
  import redir_pkg::*;
#(
  parameter  int NUM_SLOTS  = 8,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int CFG_SLOT_W = SLOT_W + 1
) (
  input  logic                  cfgValid,
  input  logic                  cfgOp,
  input  logic [CFG_SLOT_W-1:0] cfgSlot,
  input  logic                  decValid,
  input  logic [SLOT_W-1:0]     decFunc,
  output redirStrobe_t          strobe,
  output logic                  stall
);

  cfgOp_e opKind;
  logic   slotInRange;
  logic   sameSlot;
  logic   holdDispatch;

  assign opKind = cfgOp_e'(cfgOp);

  always_comb begin
    slotInRange  = cfgSlot < CFG_SLOT_W'(NUM_SLOTS);
    sameSlot     = cfgSlot[SLOT_W-1:0] == decFunc;
    // a rejected request owns the illegal flag, so nothing else is taken
    holdDispatch = cfgValid && (!slotInRange || sameSlot);

    strobe.tblWrite = cfgValid && slotInRange;
    strobe.tblClear = (opKind == CFG_CLOSE);
    strobe.issue    = decValid && !holdDispatch;
    strobe.cfgFault = cfgValid && !slotInRange;

    stall = cfgValid;
  end

endmodule

// File: rtl/redir_match.sv
module redir_match #(
  parameter int ID_W    = 128,
  parameter int NUM_EXT = 2,
  parameter logic [NUM_EXT-1:0][ID_W-1:0] EXT_IDS = '0
) (
  input  logic [ID_W-1:0]    slotId,
  output logic [NUM_EXT-1:0] extPick,
  output logic               hit
);

  logic               slotLive;
  logic [NUM_EXT-1:0] rawMatch;

  // the unbound marker never matches, even against a parameter
  assign slotLive = ~&slotId;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_cmp
    assign rawMatch[k] = slotLive && (slotId == EXT_IDS[k]);
  end

  // lowest index wins: walk downward so the last write is the lowest hit
  always_comb begin
    extPick = '0;
    for (int k = NUM_EXT - 1; k >= 0; k--) begin
      if (rawMatch[k]) begin
        extPick    = '0;
        extPick[k] = 1'b1;
      end
    end
    hit = |rawMatch;
  end

endmodule

// File: rtl/redir_dpath.sv
module redir_dpath
  import redir_pkg::*;
#(
  parameter  int NUM_SLOTS = 8,
  parameter  int ID_W      = 128,
  parameter  int NUM_EXT   = 2,
  parameter  int REG_W     = 5,
  parameter  logic [NUM_EXT-1:0][ID_W-1:0] EXT_IDS = '0,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  redirStrobe_t       strobe,
  input  logic [SLOT_W-1:0]  wrSlot,
  input  logic [ID_W-1:0]    cfgId,
  input  logic [SLOT_W-1:0]  decFunc,
  input  logic [REG_W-1:0]   decRs1,
  input  logic [REG_W-1:0]   decRs2,
  input  logic [REG_W-1:0]   decRd,
  output logic               outValid,
  output logic [NUM_EXT-1:0] outExtSel,
  output logic [SLOT_W-1:0]  outFunc,
  output logic [REG_W-1:0]   outRs1,
  output logic [REG_W-1:0]   outRs2,
  output logic [REG_W-1:0]   outRd,
  output logic               illegal
);

  localparam logic [ID_W-1:0] UNBOUND = {ID_W{1'b1}};

  logic [ID_W-1:0]    slotTbl [NUM_SLOTS];
  logic [ID_W-1:0]    readId;
  logic [NUM_EXT-1:0] extPick;
  logic               extHit;

  // identifier table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) slotTbl[s] <= UNBOUND;
    end else if (strobe.tblWrite) begin
      slotTbl[wrSlot] <= strobe.tblClear ? UNBOUND : cfgId;
    end
  end

  assign readId = slotTbl[decFunc];

  redir_match #(
    .ID_W   (ID_W),
    .NUM_EXT(NUM_EXT),
    .EXT_IDS(EXT_IDS)
  ) match_i (
    .slotId (readId),
    .extPick(extPick),
    .hit    (extHit)
  );

  // registered dispatch outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outExtSel <= '0;
      outFunc   <= '0;
      outRs1    <= '0;
      outRs2    <= '0;
      outRd     <= '0;
      illegal   <= 1'b0;
    end else begin
      outValid  <= strobe.issue && extHit;
      outExtSel <= (strobe.issue && extHit) ? extPick : '0;
      illegal   <= strobe.cfgFault || (strobe.issue && !extHit);
      if (strobe.issue) begin
        outFunc <= decFunc;
        outRs1  <= decRs1;
        outRs2  <= decRs2;
        outRd   <= decRd;
      end
    end
  end

endmodule

// File: rtl/opc_redirect.sv
module opc_redirect
  import redir_pkg::*;
#(
  parameter  int NUM_SLOTS = 8,
  parameter  int ID_W      = 128,
  parameter  int NUM_EXT   = 2,
  parameter  int REG_W     = 5,
  parameter  logic [NUM_EXT-1:0][ID_W-1:0] EXT_IDS = {
    128'h7e31_c0d4_9a52_4b1f_8e66_d2a7_04c9_35b8,
    128'h1c9b_6f02_e84d_4a73_b215_09fe_7d3c_61a0
  },
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int CFG_SLOT_W = SLOT_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgValid,
  input  logic                  cfgOp,
  input  logic [CFG_SLOT_W-1:0] cfgSlot,
  input  logic [ID_W-1:0]       cfgId,
  input  logic                  decValid,
  input  logic [SLOT_W-1:0]     decFunc,
  input  logic [REG_W-1:0]      decRs1,
  input  logic [REG_W-1:0]      decRs2,
  input  logic [REG_W-1:0]      decRd,
  output logic                  stall,
  output logic                  outValid,
  output logic [NUM_EXT-1:0]    outExtSel,
  output logic [SLOT_W-1:0]     outFunc,
  output logic [REG_W-1:0]      outRs1,
  output logic [REG_W-1:0]      outRs2,
  output logic [REG_W-1:0]      outRd,
  output logic                  illegal
);

  redirStrobe_t strobe;

  redir_ctrl #(
    .NUM_SLOTS(NUM_SLOTS)
  ) ctrl_i (
    .cfgValid(cfgValid),
    .cfgOp   (cfgOp),
    .cfgSlot (cfgSlot),
    .decValid(decValid),
    .decFunc (decFunc),
    .strobe  (strobe),
    .stall   (stall)
  );

  redir_dpath #(
    .NUM_SLOTS(NUM_SLOTS),
    .ID_W     (ID_W),
    .NUM_EXT  (NUM_EXT),
    .REG_W    (REG_W),
    .EXT_IDS  (EXT_IDS)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrSlot   (cfgSlot[SLOT_W-1:0]),
    .cfgId    (cfgId),
    .decFunc  (decFunc),
    .decRs1   (decRs1),
    .decRs2   (decRs2),
    .decRd    (decRd),
    .outValid (outValid),
    .outExtSel(outExtSel),
    .outFunc  (outFunc),
    .outRs1   (outRs1),
    .outRs2   (outRs2),
    .outRd    (outRd),
    .illegal  (illegal)
  );

endmodule

// File: rtl/opc_redirect_chk.sv
module opc_redirect_chk #(
  parameter  int NUM_SLOTS  = 8,
  parameter  int ID_W       = 128,
  parameter  int NUM_EXT    = 2,
  parameter  int REG_W      = 5,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int CFG_SLOT_W = SLOT_W + 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgValid,
  input logic [CFG_SLOT_W-1:0] cfgSlot,
  input logic                  decValid,
  input logic [SLOT_W-1:0]     decFunc,
  input logic [REG_W-1:0]      decRs1,
  input logic [REG_W-1:0]      decRs2,
  input logic [REG_W-1:0]      decRd,
  input logic                  outValid,
  input logic [NUM_EXT-1:0]    outExtSel,
  input logic [SLOT_W-1:0]     outFunc,
  input logic [REG_W-1:0]      outRs1,
  input logic [REG_W-1:0]      outRs2,
  input logic [REG_W-1:0]      outRd,
  input logic                  illegal
);

  logic badReq, sameHeld, taken, quiet;

  assign badReq   = cfgValid && (cfgSlot >= CFG_SLOT_W'(NUM_SLOTS));
  assign sameHeld = decValid && cfgValid && !badReq && (cfgSlot[SLOT_W-1:0] == decFunc);
  assign taken    = decValid && !badReq && !sameHeld;
  assign quiet    = !decValid && !badReq;

  AST_VALID_ILLEGAL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && illegal)); // R11

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $countones(outExtSel) == 1); // R4

  AST_SEL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outExtSel == '0); // R5

  AST_BAD_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    badReq |=> illegal && !outValid); // R10

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sameHeld |=> !outValid && !illegal); // R8

  AST_TAKEN_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> (outValid || illegal) && outFunc == $past(decFunc)
              && outRs1 == $past(decRs1) && outRs2 == $past(decRs2)
              && outRd == $past(decRd)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> !outValid && !illegal); // R6

endmodule

bind opc_redirect opc_redirect_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .ID_W     (ID_W),
  .NUM_EXT  (NUM_EXT),
  .REG_W    (REG_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cfgValid (cfgValid),
  .cfgSlot  (cfgSlot),
  .decValid (decValid),
  .decFunc  (decFunc),
  .decRs1   (decRs1),
  .decRs2   (decRs2),
  .decRd    (decRd),
  .outValid (outValid),
  .outExtSel(outExtSel),
  .outFunc  (outFunc),
  .outRs1   (outRs1),
  .outRs2   (outRs2),
  .outRd    (outRd),
  .illegal  (illegal)
);

// File: tb/opc_redirect_tb_top.sv
module opc_redirect_tb_top;

  localparam int ID_W    = 128;
  localparam int NUM_EXT = 3;
  localparam logic [ID_W-1:0] ID_A = 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0;
  localparam logic [ID_W-1:0] ID_B = 128'hdead_0001_beef_0002_cafe_0003_f00d_0004;
  localparam logic [ID_W-1:0] ID_C = 128'h5555_aaaa_5555_aaaa_1234_5678_9abc_def0;
  localparam logic [ID_W-1:0] ONES = {ID_W{1'b1}};
  // index 2 repeats index 0, so first-match priority is visible
  localparam logic [NUM_EXT-1:0][ID_W-1:0] IDS = {ID_A, ID_B, ID_A};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0, cfgOp = 1'b0;
  logic [3:0] cfgSlot = '0;
  logic [ID_W-1:0] cfgId = '0;
  logic decValid = 1'b0;
  logic [2:0] decFunc = '0;
  logic [4:0] decRs1 = '0, decRs2 = '0, decRd = '0;
  logic stall, outValid, illegal;
  logic [NUM_EXT-1:0] outExtSel;
  logic [2:0] outFunc;
  logic [4:0] outRs1, outRs2, outRd;

  always #5 clk = ~clk;

  opc_redirect #(
    .NUM_SLOTS(8), .ID_W(ID_W), .NUM_EXT(NUM_EXT), .REG_W(5), .EXT_IDS(IDS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgOp(cfgOp),
    .cfgSlot(cfgSlot), .cfgId(cfgId), .decValid(decValid), .decFunc(decFunc),
    .decRs1(decRs1), .decRs2(decRs2), .decRd(decRd), .stall(stall),
    .outValid(outValid), .outExtSel(outExtSel), .outFunc(outFunc),
    .outRs1(outRs1), .outRs2(outRs2), .outRd(outRd), .illegal(illegal)
  );

  typedef struct {
    int         due;
    bit         disp;
    bit         v;
    bit         ill;
    logic [2:0] sel;
    logic [2:0] fn;
    logic [4:0] r1, r2, rd;
    string      tag;
  } exp_t;

  exp_t q[$];
  logic [ID_W-1:0] model [8];
  int cyc = 0;
  int nChk = 0, nFail = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected routing derived from the requirements
  function automatic logic [2:0] expSel(input logic [ID_W-1:0] id);
    if (id == ONES) return 3'b000;
    if (id == ID_A) return 3'b001;   // ext0 beats ext2
    if (id == ID_B) return 3'b010;
    return 3'b000;
  endfunction

  // driver: one cycle of stimulus, pushes what must come out
  task automatic step(input bit cv, input bit op, input logic [3:0] slot,
                      input logic [ID_W-1:0] id, input bit dv, input logic [2:0] fn,
                      input logic [4:0] r1, input logic [4:0] r2, input logic [4:0] rd,
                      input string tag);
    exp_t e;
    bit bad, same;
    @(negedge clk);
    cfgValid = cv; cfgOp = op; cfgSlot = slot; cfgId = id;
    decValid = dv; decFunc = fn; decRs1 = r1; decRs2 = r2; decRd = rd;
    bad  = cv && (slot >= 4'd8);
    same = cv && !bad && (slot[2:0] == fn);
    if (bad) begin
      e = '{due: cyc + 1, disp: 1'b0, v: 1'b0, ill: 1'b1, sel: 3'b000,
            fn: 3'd0, r1: 5'd0, r2: 5'd0, rd: 5'd0, tag: "R10"};
      q.push_back(e);
    end else if (dv && !same) begin
      e.due = cyc + 1; e.disp = 1'b1;
      e.sel = expSel(model[fn]);
      e.v = (e.sel != 3'b000); e.ill = !e.v;
      e.fn = fn; e.r1 = r1; e.r2 = r2; e.rd = rd; e.tag = tag;
      q.push_back(e);
    end
    if (cv && !bad) model[slot[2:0]] = op ? ONES : id;
    #1;
    check(stall == cv, "R7", "stall", 128'(stall), 128'(cv));
  endtask

  task automatic openS(input logic [3:0] s, input logic [ID_W-1:0] id, input string tag);
    step(1'b1, 1'b0, s, id, 1'b0, 3'd0, 5'd0, 5'd0, 5'd0, tag);
  endtask
  task automatic closeS(input logic [3:0] s, input string tag);
    step(1'b1, 1'b1, s, '0, 1'b0, 3'd0, 5'd0, 5'd0, 5'd0, tag);
  endtask
  task automatic disp(input logic [2:0] fn, input logic [4:0] r1, input logic [4:0] r2,
                      input logic [4:0] rd, input string tag);
    step(1'b0, 1'b0, 4'd0, '0, 1'b1, fn, r1, r2, rd, tag);
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 4'd0, '0, 1'b0, 3'd0, 5'd0, 5'd0, 5'd0, "R6");
  endtask

  // monitor: compares outputs against the scoreboard queue
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && illegal)
        check(1'b0, "R11", "valid and illegal together", 128'(1), 128'(0));
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(outValid == e.v, e.tag, "outValid", 128'(outValid), 128'(e.v));
        check(illegal == e.ill, e.tag, "illegal", 128'(illegal), 128'(e.ill));
        check(outExtSel == e.sel, e.tag, "outExtSel", 128'(outExtSel), 128'(e.sel));
        if (e.disp) begin
          check({outFunc, outRs1, outRs2, outRd} == {e.fn, e.r1, e.r2, e.rd}, e.tag,
                "forwarded fields", 128'({outFunc, outRs1, outRs2, outRd}),
                128'({e.fn, e.r1, e.r2, e.rd}));
        end
      end else if (outValid || illegal) begin
        check(1'b0, "R8", "unexpected result", 128'({outValid, illegal}), 128'(0));
      end
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) model[s] = ONES;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!outValid && !illegal, "R1", "reset outputs", 128'({outValid, illegal}), 128'(0));
    rstN = 1'b1;
    // R1: every slot unbound after reset
    for (int s = 0; s < 8; s++) disp(3'(s), 5'(s), 5'(s + 1), 5'(s + 2), "R1");
    // R2 / R4: bind A (duplicated at ext2) and B
    openS(4'd0, ID_A, "R2");
    disp(3'd0, 5'd3, 5'd4, 5'd5, "R4");
    openS(4'd3, ID_B, "R2");
    disp(3'd3, 5'd31, 5'd0, 5'd17, "R2");
    // R5: unknown identifier
    openS(4'd5, ID_C, "R5");
    disp(3'd5, 5'd7, 5'd8, 5'd9, "R5");
    // R3: close
    closeS(4'd0, "R3");
    disp(3'd0, 5'd1, 5'd2, 5'd3, "R3");
    // R8: dispatch collides with its own slot write, then retried
    step(1'b1, 1'b0, 4'd2, ID_B, 1'b1, 3'd2, 5'd10, 5'd11, 5'd12, "R8");
    disp(3'd2, 5'd10, 5'd11, 5'd12, "R8");
    // R9: write to another slot does not disturb dispatch
    step(1'b1, 1'b0, 4'd4, ID_A, 1'b1, 3'd3, 5'd20, 5'd21, 5'd22, "R9");
    disp(3'd4, 5'd13, 5'd14, 5'd15, "R9");
    // R10: out-of-range slot aliasing slot 3, with a concurrent dispatch
    step(1'b1, 1'b0, 4'd11, ID_A, 1'b1, 3'd3, 5'd1, 5'd1, 5'd1, "R10");
    disp(3'd3, 5'd6, 5'd6, 5'd6, "R10");
    step(1'b1, 1'b1, 4'd15, '0, 1'b0, 3'd0, 5'd0, 5'd0, 5'd0, "R10");
    disp(3'd3, 5'd9, 5'd9, 5'd9, "R10");
    // R12: all-ones identifier stays unbound
    openS(4'd6, ONES, "R12");
    disp(3'd6, 5'd2, 5'd4, 5'd8, "R12");
    // R2: rebind slot 3 from B to A
    openS(4'd3, ID_A, "R2");
    disp(3'd3, 5'd30, 5'd29, 5'd28, "R2");
    // R6: back-to-back sweep, two operand patterns
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 8; s++)
        disp(3'(s), 5'(s * 3 + p), 5'(31 - s - p), 5'(s ^ (p * 21)), "R6");
    idle(); idle(); idle();
    check(q.size() == 0, "R8", "results outstanding", 128'(q.size()), 128'(0));
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nChk++;
    nFail++;
    $display("FAIL R6 watchdog: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule